// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of several DMA channels owns a shared transfer engine, one transfer unit at a time. Each channel has a request line, a per-channel mode bit choosing burst or cycle-steal operation, and a remaining-unit count that is loaded through a small load port. One global bit picks the arbitration policy: fixed priority, where the lowest channel number wins, or round robin, where the search for a winner starts at the channel after the one granted last.

The arbiter issues a one-hot grant and a one-cycle `unit_start` strobe for every unit it hands to the engine. The engine answers with a one-cycle `unit_done` when that unit has finished. The arbiter then decrements the granted channel's count and decides again. `unit_start` and `unit_done` form the block's only handshake. The engine applies back-pressure simply by holding back `unit_done`, and the arbiter never starts a second unit before the first one has been acknowledged. Decisions are made only while idle, or in the cycle a unit is acknowledged. A unit in progress is never taken away.

A burst channel keeps the engine from one unit to the next with no idle cycle, unless a channel that should win under the current policy is eligible. In that case the higher channel preempts the burst at the unit boundary. A cycle-steal channel releases the engine after every unit. A channel whose count reaches zero raises a one-cycle done pulse and is not granted again until it is reloaded.

Top module: `dma_arb_top`

## Requirements
- R1: After reset, `grant`, `unit_start` and `ch_done` are all zero and every count is zero, so a raised request gets no grant until its channel is loaded.
- R2: A channel is eligible only while its request is high and its count is non-zero. `grant` is one-hot or zero. Each newly issued grant is marked by `unit_start` high for exactly that cycle, and every `unit_start` corresponds to one expected unit.
- R3: With `rr_mode`=0 (fixed policy), the eligible channel with the lowest index wins. A lower-index request that arrives during a higher-index burst takes the engine at the next unit boundary, and the suspended channel resumes only after the preempting channel's count is exhausted.
- R4: With `rr_mode`=1 (round robin), the search after each unit starts at the index following the last granted channel, wrapping from N-1 to 0. Two active channels therefore alternate unit by unit, whatever their burst settings. After reset the search starts at channel 0.
- R5: A channel with `ch_burst`=1 whose acknowledged unit leaves work to do gets its next `unit_start` in the cycle right after `unit_done`, unless another channel wins that decision.
- R6: After a `unit_done` for a channel with `ch_burst`=0, `grant` is zero for exactly one cycle before the next decision. The same cycle-steal channel never receives two units back to back.
- R7: Each acknowledged unit decrements the granted channel's count by one. The acknowledge that brings the count to zero raises that channel's `ch_done` bit for one cycle, in the cycle after `unit_done`.
- R8: `unit_done` while no grant is held is ignored: no count changes and no `ch_done` pulse occurs.
- R9: A load (`ld_stb` with the binary channel index on `ld_sel` and the count on `ld_cnt`) to a channel that currently holds the grant is ignored.
- R10: A preempted channel keeps its remaining count and resumes from it, so it performs exactly the number of units it was loaded with.
- R11: While a grant is held and no `unit_done` arrives, `grant` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 0 = fixed priority, 1 = round robin |
| ch_req | input | N | Per-channel request level |
| ch_burst | input | N | Per-channel mode: 1 = burst, 0 = cycle steal |
| ld_stb | input | 1 | Load strobe for a channel count |
| ld_sel | input | IW | Binary index of the channel to load |
| ld_cnt | input | CW | Number of units to load |
| unit_done | input | 1 | Engine acknowledge: current unit finished |
| grant | output | N | One-hot owner of the engine, zero when idle |
| unit_start | output | 1 | One-cycle strobe: a new unit begins under `grant` |
| ch_done | output | N | One-cycle pulse: channel count reached zero |

## Verification
The bench targets preemption of a burst by a lower-index request under both policies. A design that finishes the burst first, or lets the suspended channel back in too early, produces a grant order the scoreboard rejects. It also checks that a preempted channel performs exactly its loaded number of units, so any lost or reset count shows up as a missing or extra start. The spacing between starts is measured for all-burst and all-cycle-steal traffic, which catches a missing idle cycle after a cycle-steal unit or a stray bubble inside a burst. Loads aimed at the owning channel and acknowledges arriving while idle are both applied, and any change to a count shows up as a wrong number of units.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    POL_FIXED = 1'b0,
    POL_ROUND = 1'b1
  } arb_pol_e;
endpackage

// File: rtl/dma_arb_chan.sv
// Per-channel remaining-unit counter with a terminal pulse.
module dma_arb_chan #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          owned,
  input  logic          dec,
  output logic          nz,
  output logic          is_one,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (dec) begin
        cnt_q <= cnt_q - 1'b1;
        done  <= (cnt_q == CW'(1));
      end else if (ld && !owned) begin
        cnt_q <= ld_val;
      end
    end
  end

  assign nz     = (cnt_q != '0);
  assign is_one = (cnt_q == CW'(1));
endmodule

// File: rtl/dma_arb_pick.sv
// Circular first-eligible search starting at base.
module dma_arb_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] base,
  output logic [N-1:0]  win_oh,
  output logic [IW-1:0] win_idx,
  output logic          any
);
  always_comb begin
    logic [IW-1:0] sel;
    win_oh  = '0;
    win_idx = '0;
    any     = 1'b0;
    sel     = '0;
    for (int k = 0; k < N; k++) begin
      sel = IW'((int'(base) + k) % N);
      if (!any && elig[sel]) begin
        any          = 1'b1;
        win_oh[sel]  = 1'b1;
        win_idx      = sel;
      end
    end
  end
endmodule

// File: rtl/dma_arb_top.sv
module dma_arb_top
  import dma_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rr_mode,
  input  logic [N-1:0]  ch_req,
  input  logic [N-1:0]  ch_burst,
  input  logic          ld_stb,
  input  logic [IW-1:0] ld_sel,
  input  logic [CW-1:0] ld_cnt,
  input  logic          unit_done,
  output logic [N-1:0]  grant,
  output logic          unit_start,
  output logic [N-1:0]  ch_done
);
  logic          busy_q;
  logic [N-1:0]  grant_q;
  logic          start_q;
  logic [IW-1:0] last_q;

  logic [N-1:0]  nz, one, dec_v, nz_after, elig, win_oh;
  logic [IW-1:0] base, win_idx;
  logic          any, ack, burst_g;
  arb_pol_e      pol;

  assign pol      = arb_pol_e'(rr_mode);
  assign ack      = busy_q & unit_done;
  assign dec_v    = grant_q & {N{ack}};
  // Eligibility as it will be once the acknowledged unit is counted.
  assign nz_after = nz & ~(dec_v & one);
  assign elig     = ch_req & (busy_q ? nz_after : nz);
  assign burst_g  = |(grant_q & ch_burst);
  assign base     = (pol == POL_ROUND)
                  ? ((last_q == IW'(N - 1)) ? '0 : last_q + 1'b1)
                  : '0;

  for (genvar gi = 0; gi < N; gi++) begin : g_chan
    dma_arb_chan #(.CW(CW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ld_stb && (ld_sel == IW'(gi))),
      .ld_val (ld_cnt),
      .owned  (grant_q[gi]),
      .dec    (dec_v[gi]),
      .nz     (nz[gi]),
      .is_one (one[gi]),
      .done   (ch_done[gi])
    );
  end

  dma_arb_pick #(.N(N), .IW(IW)) u_pick (
    .elig    (elig),
    .base    (base),
    .win_oh  (win_oh),
    .win_idx (win_idx),
    .any     (any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
      start_q <= 1'b0;
      last_q  <= IW'(N - 1);
    end else begin
      start_q <= 1'b0;
      if (!busy_q) begin
        if (any) begin
          busy_q  <= 1'b1;
          grant_q <= win_oh;
          start_q <= 1'b1;
          last_q  <= win_idx;
        end
      end else if (unit_done) begin
        if (burst_g && any) begin
          grant_q <= win_oh;
          start_q <= 1'b1;
          last_q  <= win_idx;
        end else begin
          busy_q  <= 1'b0;
          grant_q <= '0;
        end
      end
    end
  end

  assign grant      = grant_q;
  assign unit_start = start_q;
endmodule

// File: rtl/dma_arb_sva.sv
module dma_arb_sva #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] ch_burst,
  input logic         unit_done,
  input logic [N-1:0] grant,
  input logic         unit_start,
  input logic [N-1:0] ch_done
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_start_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start |-> (grant != '0));

  p_new_grant_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && (grant != $past(grant))) |-> unit_start);

  p_steal_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && ((grant & ~ch_burst) != '0)) |=> (grant == '0));

  p_done_from_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_done != '0) |-> ($past(unit_done) && ($past(grant) == ch_done)));

  p_idle_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && (grant == '0)) |=> (ch_done == '0));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && !unit_done) |=> (grant == $past(grant)));
endmodule

bind dma_arb_top dma_arb_sva #(.N(N)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_burst   (ch_burst),
  .unit_done  (unit_done),
  .grant      (grant),
  .unit_start (unit_start),
  .ch_done    (ch_done)
);

// File: tb/dma_arb_top_tb.sv
`timescale 1ns/1ps
module dma_arb_top_tb;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rr_mode = 1'b0;
  logic [N-1:0]  ch_req = '0;
  logic [N-1:0]  ch_burst = '0;
  logic          ld_stb = 1'b0;
  logic [IW-1:0] ld_sel = '0;
  logic [CW-1:0] ld_cnt = '0;
  logic          unit_done = 1'b0;
  logic [N-1:0]  grant;
  logic          unit_start;
  logic [N-1:0]  ch_done;

  always #2.5 clk = ~clk;

  dma_arb_top #(.N(N), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .ch_req(ch_req),
    .ch_burst(ch_burst), .ld_stb(ld_stb), .ld_sel(ld_sel), .ld_cnt(ld_cnt),
    .unit_done(unit_done), .grant(grant), .unit_start(unit_start),
    .ch_done(ch_done)
  );

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int done_seen [N];
  int cyc = 0;
  int first_st = -1;
  int last_st = -1;
  logic [N-1:0] prev_grant = '0;
  bit eng_en = 1'b1;
  int eng_lat = 1;
  int wait_c = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int ch);
    exp_q.push_back(ch);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < N; i++) if (ch_done[i]) done_seen[i]++;
      if (unit_start) begin
        if (first_st < 0) first_st = cyc;
        last_st = cyc;
        chk($onehot(grant), "R2", "grant one-hot at start", int'(grant), 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected unit start, grant", int'(grant), 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(grant == (4'b0001 << e), "R3/R4", "grant order",
              int'(grant), int'(4'b0001 << e));
        end
        if ((grant & ~ch_burst) != '0)
          chk(grant != prev_grant, "R6", "cycle-steal back to back",
              int'(prev_grant), 0);
      end
      prev_grant = grant;
    end
  end

  // Modelled transfer engine
  initial forever begin
    @(negedge clk);
    if (eng_en) begin
      unit_done = 1'b0;
      if (unit_start) wait_c = eng_lat;
      else if (wait_c > 0) begin
        wait_c--;
        if (wait_c == 0) unit_done = 1'b1;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ch_req = '0; ch_burst = '0; unit_done = 1'b0;
    wait_c = 0; eng_lat = 1; eng_en = 1'b1;
    repeat (3) @(negedge clk);
    exp_q.delete();
    for (int i = 0; i < N; i++) done_seen[i] = 0;
    first_st = -1; last_st = -1;
    rst_n = 1'b1;
  endtask

  task automatic load(input int ch, input int cnt);
    @(negedge clk);
    ld_stb = 1'b1; ld_sel = IW'(ch); ld_cnt = CW'(cnt);
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && grant == '0 && !unit_start) break;
    end
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, req, "units left unissued", exp_q.size(), 0);
  endtask

  task automatic wait_start();
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      if (unit_start) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, zero counts block grants
    do_reset();
    @(negedge clk);
    chk(grant == '0, "R1", "grant after reset", int'(grant), 0);
    chk(!unit_start, "R1", "start after reset", int'(unit_start), 0);
    chk(ch_done == '0, "R1", "done after reset", int'(ch_done), 0);
    ch_req = 4'b1111;
    repeat (6) @(negedge clk);
    chk(grant == '0, "R1", "grant with zero counts", int'(grant), 0);

    // R3 R5 R7: fixed, all burst, two units each
    do_reset();
    rr_mode = 1'b0; ch_burst = 4'b1111;
    for (int c = 0; c < N; c++) load(c, 2);
    for (int c = 0; c < N; c++) begin push(c); push(c); end
    ch_req = 4'b1111;
    drain("R3");
    chk(last_st - first_st == 14, "R5", "burst start span", last_st - first_st, 14);
    for (int c = 0; c < N; c++)
      chk(done_seen[c] == 1, "R7", "done pulses per channel", done_seen[c], 1);

    // R6: fixed, all cycle steal
    do_reset();
    rr_mode = 1'b0; ch_burst = 4'b0000;
    for (int c = 0; c < N; c++) load(c, 2);
    for (int c = 0; c < N; c++) begin push(c); push(c); end
    ch_req = 4'b1111;
    drain("R6");
    chk(last_st - first_st == 21, "R6", "cycle-steal start span", last_st - first_st, 21);

    // R3 R10: fixed preemption of a burst by a cycle-steal channel
    do_reset();
    rr_mode = 1'b0; ch_burst = 4'b0010;
    load(1, 4); load(0, 2);
    push(1); push(0); push(0); push(1); push(1); push(1);
    ch_req = 4'b0010;
    wait_start();
    ch_req = 4'b0011;
    drain("R3");
    chk(done_seen[1] == 1, "R10", "preempted channel finishes", done_seen[1], 1);
    chk(done_seen[0] == 1, "R3", "preempting channel done", done_seen[0], 1);

    // R4 R10: same traffic under round robin alternates per unit
    do_reset();
    rr_mode = 1'b1; ch_burst = 4'b0010;
    load(1, 4); load(0, 2);
    push(1); push(0); push(1); push(0); push(1); push(1);
    ch_req = 4'b0010;
    wait_start();
    ch_req = 4'b0011;
    drain("R4");
    chk(done_seen[1] == 1, "R10", "round-robin resumed count", done_seen[1], 1);

    // R4: round robin, four burst channels
    do_reset();
    rr_mode = 1'b1; ch_burst = 4'b1111;
    for (int c = 0; c < N; c++) load(c, 2);
    for (int r = 0; r < 2; r++) for (int c = 0; c < N; c++) push(c);
    ch_req = 4'b1111;
    drain("R4");

    // R9 R11: load to the owning channel is ignored; grant held
    do_reset();
    rr_mode = 1'b0; ch_burst = 4'b0100; eng_lat = 5;
    load(2, 2);
    push(2); push(2);
    ch_req = 4'b0100;
    wait_start();
    load(2, 7);
    chk(grant == 4'b0100, "R11", "grant held during unit", int'(grant), 4);
    drain("R9");
    chk(done_seen[2] == 1, "R9", "done after original count", done_seen[2], 1);
    chk(grant == '0, "R9", "no grant after count spent", int'(grant), 0);

    // R8: acknowledge while idle is ignored
    do_reset();
    eng_en = 1'b0; ch_burst = 4'b1000;
    load(3, 1);
    @(negedge clk); unit_done = 1'b1;
    @(negedge clk); unit_done = 1'b0;
    chk(ch_done == '0, "R8", "done after idle ack", int'(ch_done), 0);
    chk(grant == '0, "R8", "grant after idle ack", int'(grant), 0);
    eng_en = 1'b1;
    push(3);
    ch_req = 4'b1000;
    drain("R8");
    chk(done_seen[3] == 1, "R8", "count kept through idle ack", done_seen[3], 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule